// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the 16-bit control and status word of a PCI function's power management capability. Software reaches it through a plain register port that has per-byte write enables. Through it, software sets the function's power state, arms wake signalling, clears a pending wake, and picks which power rating appears in a separate data field. The block drives the current power-state code and an active-high PME request.

Two reset inputs arrive. A PCI reset clears the register. If the function can signal a wake from D3cold, the PME enable and PME status bits instead keep their values through that reset, so a wake that happened while power was off is still visible afterwards. The internal reset raised on a D3hot to D0 transition has no effect on any bit. A wake-event input sets PME status whether or not PME enable is set. The PME output is asserted only when both bits are 1.

Top module: `pm_csr_reg`

## Requirements
- R1: During and after a PCI reset (`pci_rst` high at a clock edge) with `d3cold_pme_cap` low, `rd_data` reads 0000h, `pme_out` is 0 and `pm_data` reads the select-0 rating.
- R2: While `d3cold_pme_cap` is high, a PCI reset leaves PME status (bit 15) and PME enable (bit 8) unchanged and clears every other stored field.
- R3: A pulse on `soft_rst` changes no bit of `rd_data`, `pme_out` or `pwr_state`.
- R4: Bits 1:0 hold the power state (00=D0, 01=D1, 10=D2, 11=D3). They are written from `wr_data[1:0]`, read back on `rd_data[1:0]`, and driven on `pwr_state`.
- R5: A write changes byte 0 (bits 7:0) only when `wr_be[0]` is set and byte 1 (bits 15:8) only when `wr_be[1]` is set.
- R6: A cycle with `wake_evt` high sets PME status in the next cycle, whatever the value of PME enable.
- R7: Writing 1 to bit 15 with `wr_be[1]` set clears PME status. Writing 0 there has no effect. A wake event in the same cycle as the clear wins, and the bit stays set.
- R8: `pme_out` is 1 exactly when PME status and PME enable are both 1. It is never 1 while PME enable is 0.
- R9: Bits 12:9 store any 4-bit data-select value. For selects 0 to 3, data-scale (bits 14:13) reads 00. For selects 4 to 7 it reads 01. `pm_data` reads 200 - 20*select for selects 0 to 7. For selects 8 to 15, both data-scale and `pm_data` read 0.
- R10: Bits 7:2 always read 0, and writes to bits 14:13 and 7:2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| pci_rst | input | 1 | Synchronous PCI reset, active high |
| soft_rst | input | 1 | Internal D3hot-to-D0 reset; the register ignores it |
| d3cold_pme_cap | input | 1 | High when PME from D3cold is supported; makes bits 15 and 8 sticky |
| wake_evt | input | 1 | Wake event; sets PME status |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte enables for bits 7:0 and 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| pwr_state | output | 2 | Current power-state code |
| pme_out | output | 1 | PME request, active high |
| pm_data | output | 8 | Rating selected by data-select |

## Verification
The assertions assume that `d3cold_pme_cap` is a static configuration input while a PCI reset is active. They also assume that the wake and write inputs are sampled only outside reset. The sticky-hold check therefore compares values across reset cycles only. The stimulus changes the capability input only between reset pulses. It drives every input at the falling clock edge, so each assertion sees settled values.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NBYTES  = REG_W / BYTE_W;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned SCALE_W = 2;
  localparam int unsigned NUM_RATINGS = 8;

  // Field positions decoded by neighbouring configuration logic
  localparam int unsigned STATE_LSB = 0;
  localparam int unsigned EN_BIT    = 8;
  localparam int unsigned SEL_LSB   = 9;
  localparam int unsigned SCALE_LSB = 13;
  localparam int unsigned STS_BIT   = 15;

  typedef enum logic [STATE_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  function automatic logic sel_in_range(input logic [SEL_W-1:0] sel);
    return ({28'd0, sel} < NUM_RATINGS);
  endfunction

  // Consumption ratings (0..3) use unit scale; dissipation (4..7) uses 1/10
  function automatic logic [SCALE_W-1:0] scale_of(input logic [SEL_W-1:0] sel);
    if (!sel_in_range(sel)) return '0;
    return (sel >= SEL_W'(NUM_RATINGS / 2)) ? SCALE_W'(1) : SCALE_W'(0);
  endfunction
endpackage

// File: rtl/pm_state_field.sv
module pm_state_field
  import pm_csr_pkg::*;
(
  input  logic               clk,
  input  logic               pci_rst,
  input  logic               wr_lo,
  input  logic [STATE_W-1:0] wd_state,
  output pwr_state_e         state
);
  always_ff @(posedge clk) begin
    if (pci_rst)    state <= PS_D0;
    else if (wr_lo) state <= pwr_state_e'(wd_state);
  end
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl (
  input  logic clk,
  input  logic pci_rst,
  input  logic d3cold_cap,
  input  logic wr_hi,
  input  logic wd_en,
  input  logic wd_sts,
  input  logic wake_evt,
  output logic pme_en,
  output logic pme_sts,
  output logic pme_req
);
  logic sticky_hold;
  logic sts_set;
  logic sts_clr;

  assign sticky_hold = pci_rst && d3cold_cap;
  assign sts_set     = wake_evt;
  assign sts_clr     = wr_hi && wd_sts;

  always_ff @(posedge clk) begin
    if (pci_rst) begin
      if (!sticky_hold) begin
        pme_en  <= 1'b0;
        pme_sts <= 1'b0;
      end
    end else begin
      if (wr_hi) pme_en <= wd_en;
      if (sts_set)      pme_sts <= 1'b1;
      else if (sts_clr) pme_sts <= 1'b0;
    end
  end

  assign pme_req = pme_sts && pme_en;
endmodule

// File: rtl/pm_data_sel.sv
module pm_data_sel
  import pm_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BASE_RATING = 200,
  parameter int unsigned RATING_STEP = 20
) (
  input  logic               clk,
  input  logic               pci_rst,
  input  logic               wr_hi,
  input  logic [SEL_W-1:0]   wd_sel,
  output logic [SEL_W-1:0]   sel,
  output logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  data
);
  localparam logic [DATA_W-1:0] BASE_V = DATA_W'(BASE_RATING);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(RATING_STEP);

  function automatic logic [DATA_W-1:0] rating_of(input logic [SEL_W-1:0] s);
    if (!sel_in_range(s)) return '0;
    return BASE_V - DATA_W'(s) * STEP_V;
  endfunction

  always_ff @(posedge clk) begin
    if (pci_rst)    sel <= '0;
    else if (wr_hi) sel <= wd_sel;
  end

  assign scale = scale_of(sel);
  assign data  = rating_of(sel);
endmodule

// File: rtl/pm_csr_reg.sv
module pm_csr_reg
  import pm_csr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BASE_RATING = 200,
  parameter int unsigned RATING_STEP = 20
) (
  input  logic              clk,
  input  logic              pci_rst,
  input  logic              soft_rst,
  input  logic              d3cold_pme_cap,
  input  logic              wake_evt,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [STATE_W-1:0] pwr_state,
  output logic              pme_out,
  output logic [DATA_W-1:0] pm_data
);
  logic [NBYTES-1:0]  byte_wr;
  pwr_state_e         state_q;
  logic               en_q;
  logic               sts_q;
  logic [SEL_W-1:0]   sel_q;
  logic [SCALE_W-1:0] scale_w;

  // The D3hot->D0 internal reset deliberately reaches no storage here
  logic soft_rst_unused;
  assign soft_rst_unused = soft_rst;

  for (genvar b = 0; b < NBYTES; b++) begin : g_strobe
    assign byte_wr[b] = wr_en && wr_be[b];
  end

  pm_state_field u_state (
    .clk      (clk),
    .pci_rst  (pci_rst),
    .wr_lo    (byte_wr[0]),
    .wd_state (wr_data[STATE_LSB +: STATE_W]),
    .state    (state_q)
  );

  pm_wake_ctl u_wake (
    .clk        (clk),
    .pci_rst    (pci_rst),
    .d3cold_cap (d3cold_pme_cap),
    .wr_hi      (byte_wr[1]),
    .wd_en      (wr_data[EN_BIT]),
    .wd_sts     (wr_data[STS_BIT]),
    .wake_evt   (wake_evt),
    .pme_en     (en_q),
    .pme_sts    (sts_q),
    .pme_req    (pme_out)
  );

  pm_data_sel #(
    .DATA_W      (DATA_W),
    .BASE_RATING (BASE_RATING),
    .RATING_STEP (RATING_STEP)
  ) u_data (
    .clk     (clk),
    .pci_rst (pci_rst),
    .wr_hi   (byte_wr[1]),
    .wd_sel  (wr_data[SEL_LSB +: SEL_W]),
    .sel     (sel_q),
    .scale   (scale_w),
    .data    (pm_data)
  );

  always_comb begin
    rd_data = '0;
    rd_data[STATE_LSB +: STATE_W] = state_q;
    rd_data[EN_BIT]               = en_q;
    rd_data[SEL_LSB +: SEL_W]     = sel_q;
    rd_data[SCALE_LSB +: SCALE_W] = scale_w;
    rd_data[STS_BIT]              = sts_q;
  end

  assign pwr_state = state_q;
endmodule

// File: rtl/pm_csr_chk.sv
module pm_csr_chk (
  input logic        clk,
  input logic        pci_rst,
  input logic        soft_rst,
  input logic        d3cold_pme_cap,
  input logic        wake_evt,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic [1:0]  pwr_state,
  input logic        pme_out
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!started)
    (pci_rst && !d3cold_pme_cap) |=> (rd_data == 16'h0000)); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!started)
    (pci_rst && d3cold_pme_cap) |=> ($stable(rd_data[15]) && $stable(rd_data[8]) && rd_data[1:0] == 2'b00)); // R2

  AST_SOFT_IGNORED: assert property (@(posedge clk) disable iff (pci_rst || !started)
    (soft_rst && !wr_en && !wake_evt) |=> ($stable(rd_data) && $stable(pme_out))); // R3

  AST_STATE_PORT: assert property (@(posedge clk) disable iff (!started)
    pwr_state == rd_data[1:0]); // R4

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (pci_rst || !started)
    wake_evt |=> rd_data[15]); // R6

  AST_W1C: assert property (@(posedge clk) disable iff (pci_rst || !started)
    (wr_en && wr_be[1] && wr_data[15] && !wake_evt) |=> !rd_data[15]); // R7

  AST_PME_GATED: assert property (@(posedge clk) disable iff (!started)
    pme_out == (rd_data[15] && rd_data[8])); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!started)
    rd_data[7:2] == 6'd0); // R10
endmodule

bind pm_csr_reg pm_csr_chk u_chk (
  .clk            (clk),
  .pci_rst        (pci_rst),
  .soft_rst       (soft_rst),
  .d3cold_pme_cap (d3cold_pme_cap),
  .wake_evt       (wake_evt),
  .wr_en          (wr_en),
  .wr_be          (wr_be),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .pwr_state      (pwr_state),
  .pme_out        (pme_out)
);

// File: tb/sim_pm_csr_reg.sv
`timescale 1ns/1ps
module sim_pm_csr_reg;
  logic        clk = 1'b0;
  logic        pci_rst = 1'b1, soft_rst = 1'b0, cap = 1'b0, wake = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [1:0]  pwr_state;
  logic        pme_out;
  logic [7:0]  pm_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model
  logic [1:0] m_state = 0;
  logic m_en = 0, m_sts = 0;
  logic [3:0] m_sel = 0;

  always #2 clk = ~clk;

  pm_csr_reg u0 (
    .clk(clk), .pci_rst(pci_rst), .soft_rst(soft_rst), .d3cold_pme_cap(cap),
    .wake_evt(wake), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_state(pwr_state), .pme_out(pme_out), .pm_data(pm_data)
  );

  function automatic logic [1:0] b_scale(input logic [3:0] s);
    if (s[3]) return 2'b00;
    return {1'b0, s[2]};
  endfunction

  function automatic logic [7:0] b_rating(input logic [3:0] s);
    if (s > 4'd7) return 8'd0;
    return 8'd200 - ({4'd0, s} << 4) - ({4'd0, s} << 2);
  endfunction

  function automatic logic [15:0] b_word();
    return {m_sts, b_scale(m_sel), m_sel, m_en, 6'b0, m_state};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R4 state"}, {30'd0, rd_data[1:0]}, {30'd0, m_state});
    check({tag, " R4 port"}, {30'd0, pwr_state}, {30'd0, m_state});
    check({tag, " R7 sts"}, {31'd0, rd_data[15]}, {31'd0, m_sts});
    check({tag, " R5 en"}, {31'd0, rd_data[8]}, {31'd0, m_en});
    check({tag, " R9 sel/scale"}, {17'd0, rd_data[14:9]}, {17'd0, b_scale(m_sel), m_sel});
    check({tag, " R9 data"}, {24'd0, pm_data}, {24'd0, b_rating(m_sel)});
    check({tag, " R8 pme"}, {31'd0, pme_out}, {31'd0, m_sts & m_en});
    check({tag, " R10 rsvd"}, {26'd0, rd_data[7:2]}, 32'd0);
  endtask

  // One clock: drive at negedge, update model at posedge, leave values settled
  task automatic step(input logic rst, input logic sr, input logic wk,
                      input logic we, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    pci_rst = rst; soft_rst = sr; wake = wk; wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    if (rst) begin
      if (!cap) begin m_en = 0; m_sts = 0; end
      m_state = 0; m_sel = 0;
    end else begin
      if (we && be[0]) m_state = d[1:0];
      if (we && be[1]) begin
        m_en = d[8]; m_sel = d[12:9];
        if (d[15]) m_sts = 0;
      end
      if (wk) m_sts = 1;
    end
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 2'b00, 16'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cap = 0;
    step(1, 0, 0, 0, 2'b00, 16'h0);
    step(1, 0, 0, 0, 2'b00, 16'h0);
    check("R1 reset word", {16'd0, rd_data}, 32'h0000);
    check("R1 reset pme", {31'd0, pme_out}, 32'd0);
    check("R1 reset data", {24'd0, pm_data}, 32'd200);
    idle();

    // R6: wake sets status with enable clear, no PME out
    step(0, 0, 1, 0, 2'b00, 16'h0);
    check("R6 sts set", {31'd0, rd_data[15]}, 32'd1);
    check("R8 pme gated", {31'd0, pme_out}, 32'd0);
    // R7: writing 0 to status has no effect
    step(0, 0, 0, 1, 2'b10, 16'h0000);
    check("R7 write0", {31'd0, rd_data[15]}, 32'd1);
    // enable -> PME out
    step(0, 0, 0, 1, 2'b10, 16'h0100);
    check("R8 pme on", {31'd0, pme_out}, 32'd1);
    // R7: clear and wake in the same cycle, wake wins
    step(0, 0, 1, 1, 2'b10, 16'h8100);
    check("R7 wake wins", {31'd0, rd_data[15]}, 32'd1);
    step(0, 0, 0, 1, 2'b10, 16'h8100);
    check("R7 w1c", {31'd0, rd_data[15]}, 32'd0);
    check("R7 pme released", {31'd0, pme_out}, 32'd0);
    // R5: byte enable 0 only -> upper byte untouched
    step(0, 0, 0, 1, 2'b01, 16'hFFFF);
    check("R5 lo only", {16'd0, rd_data}, {16'd0, b_word()});
    // R10: read-only bits ignore writes, R9 invalid select
    step(0, 0, 0, 1, 2'b11, 16'h7FFE);
    check("R10 ro ignored", {16'd0, rd_data}, {16'd0, b_word()});
    check("R9 invalid sel", {24'd0, pm_data}, 32'd0);
    // R3: soft reset ignored
    step(0, 0, 1, 1, 2'b11, 16'h0B03);
    step(0, 1, 0, 0, 2'b00, 16'h0);
    step(0, 1, 0, 0, 2'b00, 16'h0);
    check("R3 soft ignored", {16'd0, rd_data}, {16'd0, b_word()});
    check("R3 soft pme", {31'd0, pme_out}, 32'd1);
    // R2: sticky across PCI reset when capable
    cap = 1;
    step(1, 0, 0, 0, 2'b00, 16'h0);
    check("R2 sticky", {16'd0, rd_data}, 32'h8100);
    idle();
    cap = 0;
    step(1, 0, 0, 0, 2'b00, 16'h0);
    check("R1 clear no cap", {16'd0, rd_data}, 32'h0000);
    idle();

    // R9: every select value
    for (int s = 0; s < 16; s++) begin
      step(0, 0, 0, 1, 2'b10, 16'(s << 9));
      check_all("R9 sweep");
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic r = ($urandom_range(0, 29) == 0);
      if (r && ($urandom_range(0, 1) == 1)) cap = ~cap;
      step(r, $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), 16'($urandom));
      check_all("rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule